// File: doc/BRIEF.md
# Capture/Compare Timer Event Flags

This block is one channel of a general-purpose timer. A 16-bit counter advances by one on each enabled tick and wraps to zero after all-ones. Three general registers sit beside it. Each is set up on its own as either a capture register or a compare register. A capture register takes a copy of the counter when its trigger fires. A compare register is watched for equality with the counter. Every general register owns one sticky event flag. The flag records a capture or a compare hit so that software can poll for it.

Software reaches the block over a small synchronous register bus. Through it, software reads the flags, the counter and the general registers, and loads the counter and the general registers. A flag goes back to 0 only through a guarded handshake. Software must first read the flag while it shows 1, and then write 0 to that bit. While the channel runs in PWM mode, no flag is ever set. A capture register can also take its trigger from a compare-match pulse produced by a neighbouring channel. Such a capture still copies the counter, but it does not raise the flag.

Top module: `ccu_status`

## Requirements
- R1: After reset every flag is 0, the counter is 0 and every general register holds all-ones.
- R2: Bus address 0 returns the flags for registers A, B and C in bits 0, 1 and 2, with all higher bits 0. Address 1 is the counter, addresses 2, 3 and 4 are general registers A, B and C, and every other address reads as 0.
- R3: With tick_en high, the counter rises by one per clock and wraps from 0xFFFF to 0x0000. A bus write to address 1 loads it instead.
- R4: A register in capture mode with its pin source selected detects the rising edge of its pin through a two-stage synchronizer. On the third rising clock edge after the pin rises, the register loads the counter and its flag is set.
- R5: A register in compare mode sets its flag on the clock edge after the counter equals it.
- R6: While pwm_mode is high, no flag goes from 0 to 1. Captures still load their registers.
- R7: A capture register whose trig_ext bit is 1 loads the counter on each cycle that ext_cmp_match is high, and never sets its flag. Its pin is ignored.
- R8: A flag clears when 0 is written to its bit at address 0, provided that bit was read as 1 since the flag was last set.
- R9: Writing 0 to a flag that has not been read as 1 since it was last set leaves it at 1. Writing 1 to any flag bit changes nothing.
- R10: A set event in the same cycle as a valid clearing write leaves the flag at 1. A set event also withdraws any earlier read of that bit.
- R11: A bus write to addresses 2 to 4 loads the chosen general register. A capture in the same cycle takes priority over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_en | input | 1 | Counter advance enable |
| pwm_mode | input | 1 | PWM mode, blocks all flag setting |
| gr_is_cap | input | 3 | Per register: 1 = capture, 0 = compare (bit 0 = A) |
| trig_ext | input | 3 | Per register: capture source is ext_cmp_match instead of the pin |
| cap_pin | input | 3 | Asynchronous capture pins |
| ext_cmp_match | input | 1 | Compare-match pulse from the neighbouring channel |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |

## Verification
The bound checker watches several behaviours on every cycle. A set event always leaves the flag at 1, and a flag falls only after a bus write of 0 to its bit. PWM mode never lets a flag rise, and an externally triggered capture raises no set event. Each capture loads the counter value of its own cycle, each compare hit sets the flag, and the counter steps by one when ticked. Other behaviours show only through the directed scenarios: the three-edge capture latency, the read-arm sequence across several bus accesses, a clear blocked by an ongoing match, and the reset values seen through the bus map.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

  localparam int ADR_STAT = 0;
  localparam int ADR_CNT  = 1;
  localparam int ADR_GR0  = 2;

  // Decides whether a register's event raises its flag in this cycle.
  function automatic logic flag_set(input logic pwm, input logic is_cap,
                                    input logic ext_sel, input logic pin_rise,
                                    input logic cmp_hit);
    if (pwm)    return 1'b0;
    if (is_cap) return !ext_sel && pin_rise;
    return cmp_hit;
  endfunction

endpackage

// File: rtl/ccu_counter.sv
module ccu_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (ld)   cnt <= ld_val;
    else if (tick) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ccu_cap_edge.sv
module ccu_cap_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], pin};
      prev <= sh[STAGES-1];
    end
  end

  assign rise = sh[STAGES-1] & ~prev;
endmodule

// File: rtl/ccu_gr.sv
module ccu_gr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_ld,
  input  logic [W-1:0] bus_val,
  input  logic         cap,
  input  logic [W-1:0] cap_val,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '1;
    else if (cap)    q <= cap_val;
    else if (bus_ld) q <= bus_val;
  end
endmodule

// File: rtl/ccu_flag_bit.sv
module ccu_flag_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic rd_stb,
  input  logic wr_stb,
  input  logic wr_bit,
  output logic flag
);
  logic arm;
  logic clr_ev;

  assign clr_ev = wr_stb && !wr_bit && arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      arm  <= 1'b0;
    end else if (set_ev) begin
      flag <= 1'b1;
      arm  <= 1'b0;
    end else if (clr_ev) begin
      flag <= 1'b0;
      arm  <= 1'b0;
    end else if (rd_stb) begin
      arm  <= flag;
    end
  end
endmodule

// File: rtl/ccu_status.sv
module ccu_status #(
  parameter int CNT_W       = 16,
  parameter int NUM_GR      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              pwm_mode,
  input  logic [NUM_GR-1:0] gr_is_cap,
  input  logic [NUM_GR-1:0] trig_ext,
  input  logic [NUM_GR-1:0] cap_pin,
  input  logic              ext_cmp_match,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata
);
  import ccu_pkg::*;

  logic                         rd_stat;
  logic                         wr_stat;
  logic                         cnt_ld;
  logic [CNT_W-1:0]             cnt_q;
  logic [NUM_GR-1:0][CNT_W-1:0] gr_q;
  logic [NUM_GR-1:0]            pin_rise;
  logic [NUM_GR-1:0]            cap_ev;
  logic [NUM_GR-1:0]            cmp_hit;
  logic [NUM_GR-1:0]            set_ev;
  logic [NUM_GR-1:0]            gr_ld;
  logic [NUM_GR-1:0]            flags;

  assign rd_stat = bus_sel && !bus_wr && (bus_addr == ADDR_W'(ADR_STAT));
  assign wr_stat = bus_sel &&  bus_wr && (bus_addr == ADDR_W'(ADR_STAT));
  assign cnt_ld  = bus_sel &&  bus_wr && (bus_addr == ADDR_W'(ADR_CNT));

  ccu_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .ld(cnt_ld),
    .ld_val(bus_wdata), .cnt(cnt_q)
  );

  for (genvar i = 0; i < NUM_GR; i++) begin : g_ch
    ccu_cap_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin(cap_pin[i]), .rise(pin_rise[i])
    );

    assign cap_ev[i]  = gr_is_cap[i] && (trig_ext[i] ? ext_cmp_match : pin_rise[i]);
    assign cmp_hit[i] = !gr_is_cap[i] && (cnt_q == gr_q[i]);
    assign set_ev[i]  = flag_set(pwm_mode, gr_is_cap[i], trig_ext[i],
                                 pin_rise[i], cmp_hit[i]);
    assign gr_ld[i]   = bus_sel && bus_wr && (bus_addr == ADDR_W'(ADR_GR0 + i));

    ccu_gr #(.W(CNT_W)) u_gr (
      .clk(clk), .rst_n(rst_n), .bus_ld(gr_ld[i]), .bus_val(bus_wdata),
      .cap(cap_ev[i]), .cap_val(cnt_q), .q(gr_q[i])
    );

    ccu_flag_bit u_flag (
      .clk(clk), .rst_n(rst_n), .set_ev(set_ev[i]), .rd_stb(rd_stat),
      .wr_stb(wr_stat), .wr_bit(bus_wdata[i]), .flag(flags[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(ADR_STAT)) bus_rdata = CNT_W'(flags);
    if (bus_addr == ADDR_W'(ADR_CNT))  bus_rdata = cnt_q;
    for (int k = 0; k < NUM_GR; k++)
      if (bus_addr == ADDR_W'(ADR_GR0 + k)) bus_rdata = gr_q[k];
  end
endmodule

// File: rtl/ccu_status_chk.sv
module ccu_status_chk #(
  parameter int CNT_W  = 16,
  parameter int NUM_GR = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         tick_en,
  input logic                         pwm_mode,
  input logic [NUM_GR-1:0]            gr_is_cap,
  input logic [NUM_GR-1:0]            trig_ext,
  input logic                         wr_stat_port,
  input logic [NUM_GR-1:0]            stat_wbits,
  input logic                         cnt_ld,
  input logic [NUM_GR-1:0]            flags,
  input logic [CNT_W-1:0]             cnt_q,
  input logic [NUM_GR-1:0][CNT_W-1:0] gr_q,
  input logic [NUM_GR-1:0]            set_ev,
  input logic [NUM_GR-1:0]            cap_ev
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !cnt_ld) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R3

  AST_PWM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_mode |=> ((flags & ~$past(flags)) == '0)); // R6

  for (genvar i = 0; i < NUM_GR; i++) begin : g_a
    AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      cap_ev[i] |=> gr_q[i] == $past(cnt_q)); // R4

    AST_CMP_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwm_mode && !gr_is_cap[i] && cnt_q == gr_q[i]) |=> flags[i]); // R5

    AST_EXT_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (gr_is_cap[i] && trig_ext[i]) |-> !set_ev[i]); // R7

    AST_CLR_BY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags[i]) |-> ($past(wr_stat_port) && !$past(stat_wbits[i]))); // R8

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev[i] |=> flags[i]); // R10
  end
endmodule

bind ccu_status ccu_status_chk #(.CNT_W(CNT_W), .NUM_GR(NUM_GR)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pwm_mode(pwm_mode),
  .gr_is_cap(gr_is_cap), .trig_ext(trig_ext), .wr_stat_port(wr_stat),
  .stat_wbits(bus_wdata[NUM_GR-1:0]), .cnt_ld(cnt_ld), .flags(flags),
  .cnt_q(cnt_q), .gr_q(gr_q), .set_ev(set_ev), .cap_ev(cap_ev)
);

// File: tb/ccu_status_bench.sv
module ccu_status_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        pwm_mode = 1'b0;
  logic [2:0]  gr_is_cap = 3'b111;
  logic [2:0]  trig_ext = 3'b000;
  logic [2:0]  cap_pin = 3'b000;
  logic        ext_cmp_match = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ccu_status u_ccu_status (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pwm_mode(pwm_mode),
    .gr_is_cap(gr_is_cap), .trig_ext(trig_ext), .cap_pin(cap_pin),
    .ext_cmp_match(ext_cmp_match), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(3'd0, d); chk("R1 flags", d, 16'h0000);
    rd(3'd1, d); chk("R1 counter", d, 16'h0000);
    rd(3'd2, d); chk("R1 GRA", d, 16'hFFFF);
    rd(3'd6, d); chk("R2 unmapped", d, 16'h0000);
  endtask

  task automatic t_gr_write();
    logic [15:0] d;
    wr(3'd3, 16'h1234);
    rd(3'd3, d); chk("R11 GRB write", d, 16'h1234);
  endtask

  task automatic t_wrap();
    logic [15:0] d;
    wr(3'd1, 16'hFFFE);
    tick_en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); tick_en = 1'b0;
    rd(3'd1, d); chk("R3 wrap", d, 16'h0001);
  endtask

  task automatic t_capture_clear();
    logic [15:0] d;
    wr(3'd1, 16'h0055);
    @(negedge clk); cap_pin[2] = 1'b1;
    repeat (3) @(posedge clk);
    wr(3'd0, 16'h0000);                       // not armed: no effect
    rd(3'd0, d); chk("R4 R9 flag C set and held", d, 16'h0004);
    rd(3'd4, d); chk("R4 GRC captured", d, 16'h0055);
    wr(3'd0, 16'h0007);                       // ones: no effect
    rd(3'd0, d); chk("R9 write one", d, 16'h0004);
    wr(3'd0, 16'h0000);
    rd(3'd0, d); chk("R8 cleared", d, 16'h0000);
    @(negedge clk); cap_pin[2] = 1'b0;
    repeat (4) @(posedge clk);
    rd(3'd0, d); chk("R4 falling edge quiet", d, 16'h0000);
  endtask

  task automatic t_compare();
    logic [15:0] d;
    wr(3'd1, 16'h0100);
    wr(3'd2, 16'h0105);
    @(negedge clk); gr_is_cap[0] = 1'b0; tick_en = 1'b1;
    repeat (8) @(posedge clk);
    @(negedge clk); tick_en = 1'b0;
    rd(3'd0, d); chk("R5 compare flag A", d, 16'h0001);
    wr(3'd1, 16'h0105);                       // held match
    rd(3'd0, d);
    wr(3'd0, 16'h0000);
    rd(3'd0, d); chk("R10 set beats clear", d, 16'h0001);
    wr(3'd1, 16'h0200);
    rd(3'd0, d);
    wr(3'd0, 16'h0000);
    rd(3'd0, d); chk("R8 clear after match", d, 16'h0000);
  endtask

  task automatic t_pwm();
    logic [15:0] d;
    @(negedge clk); pwm_mode = 1'b1;
    wr(3'd1, 16'h0105);                       // matches GRA
    @(negedge clk); cap_pin[1] = 1'b1;
    repeat (4) @(posedge clk);
    rd(3'd0, d); chk("R6 no flag in pwm", d, 16'h0000);
    rd(3'd3, d); chk("R6 capture still loads", d, 16'h0105);
    @(negedge clk); pwm_mode = 1'b0; cap_pin[1] = 1'b0;
    rd(3'd0, d); chk("R5 match after pwm", d, 16'h0001);
    @(negedge clk); gr_is_cap[0] = 1'b1;
    rd(3'd0, d);
    wr(3'd0, 16'h0000);
  endtask

  task automatic t_ext();
    logic [15:0] d;
    @(negedge clk); trig_ext[1] = 1'b1;
    wr(3'd1, 16'h0777);
    @(negedge clk); ext_cmp_match = 1'b1;
    @(posedge clk);
    @(negedge clk); ext_cmp_match = 1'b0;
    rd(3'd3, d); chk("R7 ext capture loads", d, 16'h0777);
    rd(3'd0, d); chk("R7 ext no flag", d, 16'h0000);
    wr(3'd1, 16'h0888);
    @(negedge clk); cap_pin[1] = 1'b1;
    repeat (4) @(posedge clk);
    rd(3'd3, d); chk("R7 pin ignored", d, 16'h0777);
    rd(3'd0, d); chk("R7 pin no flag", d, 16'h0000);
    @(negedge clk); cap_pin[1] = 1'b0; trig_ext[1] = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_gr_write();
    t_wrap();
    t_capture_clear();
    t_compare();
    t_pwm();
    t_ext();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule